// File: doc/BRIEF.md
# Fractional UART Baud-Rate Generator

This block turns a reference clock into the 16x-oversampling tick enable that a UART transmitter and receiver share. The divide ratio is programmable as a 16-bit whole part plus a 6-bit fraction counted in sixty-fourths of a reference cycle. The fraction is dithered by a phase accumulator, so each tick period is either the whole part or one cycle longer. Over any 64 consecutive periods the total comes to exactly whole*64 + fraction reference cycles.

Software writes the two halves of the divisor through separate write strobes into holding registers. The holding pair becomes the active divisor only at a safe point. That happens on the character-done pulse from the UART core, or at once while the core reports that it is idle. An illegal pair is flagged as soon as it is written. While the active pair is illegal, or nothing has been loaded since reset, the generator issues no ticks and reports that it has no usable divisor.

Top module: `baud_frac_gen`

## Requirements
- R1: After reset, `tick`, `divisor_valid` and `setting_error` are all 0.
- R2: `tick` is never 1 unless `divisor_valid` is 1. No tick is issued after reset until a legal divisor has been loaded.
- R3: With an active legal pair (W, F), any 64 consecutive tick periods together last exactly W*64 + F reference cycles.
- R4: Each single tick period lasts W or W+1 reference cycles, and exactly W when F is 0. `tick` is high for one cycle per period, so W = 1 with F = 0 gives a tick on every cycle.
- R5: A whole part of 0 is illegal. Once such a pair is active, `divisor_valid` is 0 and no ticks occur.
- R6: A whole part of 0xFFFF with a non-zero fraction is illegal. 0xFFFF with fraction 0 is legal.
- R7: While `core_idle` is 0, written values do not change the active divisor, so the tick spacing stays the same. They take effect after the next `char_done` pulse.
- R8: While `core_idle` is 1, a written value becomes active within two cycles of its write strobe, with no `char_done`.
- R9: `setting_error` is 1 from the cycle after a write that leaves the holding pair illegal (at least one half written since reset). It is 0 from the cycle after a write that leaves the pair legal.
- R10: A fraction write uses only `wr_data[5:0]`. The upper bits of `wr_data` are ignored for the fraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| int_wr | input | 1 | Write strobe for the whole part of the divisor |
| frac_wr | input | 1 | Write strobe for the fractional part |
| wr_data | input | 16 | Write data; the fraction takes bits 5:0 |
| core_idle | input | 1 | UART core has no character in flight |
| char_done | input | 1 | One-cycle pulse at the end of a character |
| tick | output | 1 | One-cycle 16x oversampling enable |
| divisor_valid | output | 1 | Active divisor is loaded and legal |
| setting_error | output | 1 | Holding pair is illegal |

## Verification
The hardest case to reach is a divisor write that lands while a character is in flight. If the generator swapped in the new divisor at that moment, the result would be invisible unless the tick spacing is timed before and after the eventual boundary. The bench clears `core_idle`, rewrites the whole part, and times 64 full periods to show that the old spacing continues. It then pulses `char_done` and times another 64 periods to see the new spacing. The dither itself is covered by a full sweep of all 64 fractions at several small whole parts, with the span of 64 periods compared against W*64 + F.

// File: rtl/baud_pkg.sv
package baud_pkg;

  parameter int BAUD_INT_W  = 16;
  parameter int BAUD_FRAC_W = 6;

  // Legality of a whole/fraction pair: whole part non-zero, and the
  // largest whole part only with a zero fraction.
  function automatic logic div_legal(input logic [31:0] whole,
                                     input logic [31:0] frac,
                                     input int          whole_w);
    logic [31:0] top_val;
    top_val = (32'd1 << whole_w) - 32'd1;
    return (whole != 32'd0) && !((whole == top_val) && (frac != 32'd0));
  endfunction

endpackage

// File: rtl/divisor_shadow.sv
module divisor_shadow #(
  parameter int INT_W  = baud_pkg::BAUD_INT_W,
  parameter int FRAC_W = baud_pkg::BAUD_FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              int_wr,
  input  logic              frac_wr,
  input  logic [INT_W-1:0]  wr_data,
  input  logic              core_idle,
  input  logic              char_done,
  output logic [INT_W-1:0]  act_int,
  output logic [FRAC_W-1:0] act_frac,
  output logic              act_loaded,
  output logic              load_now,
  output logic              setting_error
);

  logic [INT_W-1:0]  sh_int;
  logic [FRAC_W-1:0] sh_frac;
  logic              sh_written;
  logic              pending;

  // holding registers
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_int     <= '0;
      sh_frac    <= '0;
      sh_written <= 1'b0;
    end else begin
      if (int_wr) begin
        sh_int     <= wr_data;
        sh_written <= 1'b1;
      end
      if (frac_wr) begin
        sh_frac    <= wr_data[FRAC_W-1:0];
        sh_written <= 1'b1;
      end
    end
  end

  assign load_now = pending && (core_idle || char_done);

  // pending transfer; a write in the load cycle re-arms it
  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
    end else if (int_wr || frac_wr) begin
      pending <= 1'b1;
    end else if (load_now) begin
      pending <= 1'b0;
    end
  end

  // active divisor, only replaced at a character boundary or when idle
  always_ff @(posedge clk) begin
    if (rst) begin
      act_int    <= '0;
      act_frac   <= '0;
      act_loaded <= 1'b0;
    end else if (load_now) begin
      act_int    <= sh_int;
      act_frac   <= sh_frac;
      act_loaded <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      setting_error <= 1'b0;
    end else if (int_wr || frac_wr) begin
      setting_error <= !baud_pkg::div_legal(
        32'(int_wr  ? wr_data : sh_int),
        32'(frac_wr ? wr_data[FRAC_W-1:0] : sh_frac),
        INT_W);
    end
  end

  p_hold_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (!core_idle && !char_done) |=> ($stable(act_int) && $stable(act_frac)));

  p_idle_loads_r8: assert property (@(posedge clk) disable iff (rst)
    (core_idle && pending && !int_wr && !frac_wr) |=> !pending);

endmodule

// File: rtl/frac_dither.sv
module frac_dither #(
  parameter int FRAC_W = baud_pkg::BAUD_FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              step,
  input  logic [FRAC_W-1:0] frac,
  output logic              ext
);

  logic [FRAC_W-1:0] acc;
  logic [FRAC_W:0]   sum;

  assign sum = {1'b0, acc} + {1'b0, frac};

  // carry out of the phase accumulator stretches the following period
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc <= '0;
      ext <= 1'b0;
    end else if (step) begin
      acc <= sum[FRAC_W-1:0];
      ext <= sum[FRAC_W];
    end
  end

  p_zero_frac_r3: assert property (@(posedge clk) disable iff (rst)
    (frac == '0) |-> !ext);

endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int INT_W = baud_pkg::BAUD_INT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic [INT_W-1:0] div_int,
  input  logic             ext,
  output logic             wrap,
  output logic             tick
);

  logic [INT_W-1:0] cnt;
  logic [INT_W-1:0] lim;

  assign lim  = div_int - INT_W'(1) + INT_W'(ext);
  assign wrap = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || clear || !run) begin
      cnt <= '0;
    end else if (wrap) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + INT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tick <= 1'b0;
    else     tick <= wrap;
  end

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= lim));

endmodule

// File: rtl/baud_frac_gen.sv
module baud_frac_gen #(
  parameter int INT_W  = baud_pkg::BAUD_INT_W,
  parameter int FRAC_W = baud_pkg::BAUD_FRAC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             int_wr,
  input  logic             frac_wr,
  input  logic [INT_W-1:0] wr_data,
  input  logic             core_idle,
  input  logic             char_done,
  output logic             tick,
  output logic             divisor_valid,
  output logic             setting_error
);

  logic [INT_W-1:0]  act_int;
  logic [FRAC_W-1:0] act_frac;
  logic              act_loaded;
  logic              load_now;
  logic              ext;
  logic              wrap;
  logic              run;

  divisor_shadow #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_shadow (
    .clk(clk), .rst(rst), .int_wr(int_wr), .frac_wr(frac_wr),
    .wr_data(wr_data), .core_idle(core_idle), .char_done(char_done),
    .act_int(act_int), .act_frac(act_frac), .act_loaded(act_loaded),
    .load_now(load_now), .setting_error(setting_error)
  );

  assign run = act_loaded &&
               baud_pkg::div_legal(32'(act_int), 32'(act_frac), INT_W);

  frac_dither #(.FRAC_W(FRAC_W)) u_dither (
    .clk(clk), .rst(rst), .clear(load_now), .step(wrap),
    .frac(act_frac), .ext(ext)
  );

  tick_counter #(.INT_W(INT_W)) u_count (
    .clk(clk), .rst(rst), .clear(load_now), .run(run),
    .div_int(act_int), .ext(ext), .wrap(wrap), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (rst) divisor_valid <= 1'b0;
    else     divisor_valid <= run;
  end

  p_tick_needs_valid_r2: assert property (@(posedge clk) disable iff (rst)
    tick |-> divisor_valid);

  p_valid_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    divisor_valid |=> ($past(act_int) != '0) || !divisor_valid);

endmodule

// File: tb/sim_baud_frac_gen.sv
module sim_baud_frac_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        int_wr = 1'b0;
  logic        frac_wr = 1'b0;
  logic [15:0] wr_data = '0;
  logic        core_idle = 1'b1;
  logic        char_done = 1'b0;
  logic        tick;
  logic        divisor_valid;
  logic        setting_error;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  baud_frac_gen u0 (
    .clk(clk), .rst(rst), .int_wr(int_wr), .frac_wr(frac_wr),
    .wr_data(wr_data), .core_idle(core_idle), .char_done(char_done),
    .tick(tick), .divisor_valid(divisor_valid), .setting_error(setting_error)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_int(input logic [15:0] v);
    @(negedge clk); int_wr = 1'b1; wr_data = v;
    @(negedge clk); int_wr = 1'b0;
  endtask

  task automatic wr_frac(input logic [15:0] v);
    @(negedge clk); frac_wr = 1'b1; wr_data = v;
    @(negedge clk); frac_wr = 1'b0;
  endtask

  // time n periods; span and per-period extremes
  task automatic measure(input int n, output int span, output int pmin,
                         output int pmax);
    int first;
    int last;
    int seen;
    int guard;
    seen = 0; guard = 0; pmin = 1 << 30; pmax = 0; first = 0; last = 0;
    while (seen <= n && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (tick) begin
        if (seen == 0) first = cyc;
        else begin
          if (cyc - last < pmin) pmin = cyc - last;
          if (cyc - last > pmax) pmax = cyc - last;
        end
        last = cyc;
        seen++;
      end
    end
    span = last - first;
  endtask

  task automatic count_ticks(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tick) cnt++;
    end
  endtask

  task automatic run_pair(input int w, input int f, input logic [9:0] junk);
    int span;
    int pmin;
    int pmax;
    wr_int(16'(w));
    wr_frac({junk, 6'(f)});
    repeat (4) @(negedge clk);
    check("R8 valid after idle load", int'(divisor_valid), 1);
    measure(64, span, pmin, pmax);
    check("R3/R10 span of 64 periods", span, w * 64 + f);
    check("R4 shortest period", pmin, w);
    check("R4 longest period", pmax, (f != 0) ? w + 1 : w);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cnt;
    int span;
    int pmin;
    int pmax;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 tick after reset", int'(tick), 0);
    check("R1 valid after reset", int'(divisor_valid), 0);
    check("R1 error after reset", int'(setting_error), 0);

    count_ticks(100, cnt);
    check("R2 no ticks before load", cnt, 0);

    // sweep: every fraction at small whole parts, junk in upper bits (R10)
    for (int w = 1; w <= 3; w++)
      for (int f = 0; f < 64; f++)
        run_pair(w, f, 10'((w * 37 + f * 11) & 10'h3FF));
    run_pair(7, 17, 10'h3FF);
    run_pair(16, 0, 10'h000);
    run_pair(5, 63, 10'h2AA);

    // R5: whole part of zero
    wr_int(16'd0);
    check("R9 error after zero write", int'(setting_error), 1);
    repeat (3) @(negedge clk);
    check("R5 valid low for zero", int'(divisor_valid), 0);
    count_ticks(200, cnt);
    check("R5 no ticks for zero", cnt, 0);

    // R6: top whole part
    wr_frac(16'd1);
    wr_int(16'hFFFF);
    check("R6 error FFFF with fraction", int'(setting_error), 1);
    repeat (3) @(negedge clk);
    check("R6 valid low FFFF with fraction", int'(divisor_valid), 0);
    wr_frac(16'd0);
    check("R6 error clear FFFF no fraction", int'(setting_error), 0);
    repeat (3) @(negedge clk);
    check("R6 valid FFFF no fraction", int'(divisor_valid), 1);

    // R7: deferred update while busy
    run_pair(2, 0, 10'h000);
    @(negedge clk); core_idle = 1'b0;
    wr_int(16'd5);
    check("R9 error low for legal write", int'(setting_error), 0);
    measure(64, span, pmin, pmax);
    check("R7 old spacing while busy", span, 128);
    @(negedge clk); char_done = 1'b1;
    @(negedge clk); char_done = 1'b0;
    repeat (3) @(negedge clk);
    measure(64, span, pmin, pmax);
    check("R7 new spacing after char_done", span, 320);
    check("R7 valid after char_done", int'(divisor_valid), 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule